// File: doc/BRIEF.md
# Input-Queued Cell Crossbar with Per-Destination Queues

This block is a square cell switch with a fixed number of ports. Every ingress port sorts arriving cells into a private queue per egress port. Cells that wait for a busy egress port therefore never block cells behind them that are headed elsewhere. Each cycle, one round-robin arbiter per egress port picks one ingress port that holds a cell for it. An ingress port that wins more than one arbiter in the same cycle keeps only the lowest-numbered egress port. The crossbar then moves the winning head cells across as a one-to-one mapping. Cells that lose stay in their queues.

An upstream agent presents a cell with a valid flag, a destination port number and a payload. It may leave the cell only in a cycle where the ingress ready is high. A cell that is accepted on a clock edge can leave at the earliest in the cycle after that edge. The egress side has no backpressure. A cell shown with egress valid high is taken on the next clock edge and is removed from its queue.

Top module: `voq_xbar_switch`

## Requirements
- R1: Each ingress port has one queue for each egress port, NumPorts×NumPorts queues in all, each holding QueueDepth cells. Cells from the same ingress to the same egress leave in the order they were accepted, with their payload unchanged.
- R2: In any cycle an egress port carries a cell from at most one ingress port, and an ingress port sends at most one cell.
- R3: A cell that loses arbitration stays in its queue and leaves in a later cycle. No accepted cell is lost, so after the traffic drains the count of delivered cells equals the count of accepted cells.
- R4: A cell at the head of a queue whose egress port is free can leave even while the same ingress port holds cells waiting for a busy egress port.
- R5: Each egress port grants the first ingress port, counting upward with wrap-around from its pointer, whose queue for that egress port is not empty. All pointers are 0 after reset.
- R6: An egress pointer changes only in a cycle in which that egress port delivers a cell. It then becomes the served ingress index plus one, modulo NumPorts.
- R7: An ingress port granted by several egress ports in one cycle sends only to the lowest-numbered one. The other egress ports stay idle in that cycle, and their pointers do not move.
- R8: Ingress ready is low exactly when the queue selected by that port's current destination holds QueueDepth cells, and a cell offered then is not stored. A pop in the same cycle does not raise ready.
- R9: During and right after reset all queues are empty, every egress valid is low and every ingress ready is high.
- R10: A cell accepted on a clock edge shows on its egress port in the following cycle at the earliest. Egress valid and payload come combinationally from the queue heads, and the cell leaves on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | NumPorts | Per-ingress cell present |
| inDest | input | NumPorts×PortIdxW | Per-ingress destination egress number |
| inData | input | NumPorts×DataWidth | Per-ingress cell payload |
| inReady | output | NumPorts | Per-ingress acceptance for the current destination |
| outValid | output | NumPorts | Per-egress cell delivered this cycle |
| outData | output | NumPorts×DataWidth | Per-egress cell payload, zero when idle |

## Verification
A bench-side queue model with its own pointers predicts every egress valid, payload and ingress ready, cycle by cycle. The bench focuses on three corner cases. The first is a hotspot where all ingress ports aim at one egress port until queues fill: a design with a wrong full test would drop or duplicate cells, or would keep ready high. The second is an ingress port granted by two egress ports at once: a design without the lowest-index rule would send one cell twice or advance a pointer with no transfer. The third is a head-of-line scenario in which a lone cell for an idle egress port must leave while a backlog for another port stays queued. A design with a single ingress queue would hold that cell back. Finally, the bench drains all traffic and compares the accepted and delivered counts to catch lost cells.

// File: rtl/voq_pkg.sv
package voq_pkg;
  parameter int unsigned NumPorts   = 4;
  parameter int unsigned QueueDepth = 4;
  parameter int unsigned DataWidth  = 32;

  localparam int unsigned PortIdxW = (NumPorts > 1) ? $clog2(NumPorts) : 1;
  localparam int unsigned QAddrW   = (QueueDepth > 1) ? $clog2(QueueDepth) : 1;
  localparam int unsigned QCountW  = $clog2(QueueDepth + 1);

  typedef logic [PortIdxW-1:0]  portIdx_t;
  typedef logic [DataWidth-1:0] cell_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic [NumPorts-1:0][NumPorts-1:0] popQ;    // [ingress][egress]
    logic [NumPorts-1:0]               outFire; // per egress
    portIdx_t [NumPorts-1:0]           outSel;  // granted ingress per egress
  } xbarStrobe_t;
endpackage

// File: rtl/voq_fifo.sv
module voq_fifo #(
  parameter int unsigned Depth = 4,
  parameter int unsigned Width = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [Width-1:0] wrData,
  input  logic             rdEn,
  output logic [Width-1:0] rdData,
  output logic             notEmpty,
  output logic             full
);
  localparam int unsigned AddrW  = (Depth > 1) ? $clog2(Depth) : 1;
  localparam int unsigned CountW = $clog2(Depth + 1);

  logic [Width-1:0]  mem [Depth];
  logic [AddrW-1:0]  wrPtr, rdPtr;
  logic [CountW-1:0] count;
  logic              doWr, doRd;

  assign notEmpty = (count != '0);
  assign full     = (count == CountW'(Depth));
  assign doWr     = wrEn && !full;
  assign doRd     = rdEn && notEmpty;
  assign rdData   = mem[rdPtr];

  function automatic logic [AddrW-1:0] bump(input logic [AddrW-1:0] p);
    return (p == AddrW'(Depth - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doWr) wrPtr <= bump(wrPtr);
      if (doRd) rdPtr <= bump(rdPtr);
      case ({doWr, doRd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (doWr) mem[wrPtr] <= wrData;
  end
endmodule

// File: rtl/voq_rr_arb.sv
module voq_rr_arb
  import voq_pkg::*;
(
  input  logic [NumPorts-1:0] req,
  input  portIdx_t            ptr,
  output logic                gntValid,
  output portIdx_t            gntIdx
);
  always_comb begin
    gntValid = 1'b0;
    gntIdx   = '0;
    for (int k = 0; k < int'(NumPorts); k++) begin
      int cand;
      cand = int'(ptr) + k;
      if (cand >= int'(NumPorts)) cand = cand - int'(NumPorts);
      if (!gntValid && req[cand]) begin
        gntValid = 1'b1;
        gntIdx   = portIdx_t'(cand);
      end
    end
  end
endmodule

// File: rtl/voq_datapath.sv
module voq_datapath
  import voq_pkg::*;
(
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [NumPorts-1:0]               inValid,
  input  portIdx_t [NumPorts-1:0]           inDest,
  input  cell_t [NumPorts-1:0]              inData,
  input  xbarStrobe_t                       strobe,
  output logic [NumPorts-1:0]               inReady,
  output cell_t [NumPorts-1:0]              outData,
  output logic [NumPorts-1:0][NumPorts-1:0] notEmpty
);
  logic [NumPorts-1:0][NumPorts-1:0] fullM;
  cell_t headM [NumPorts][NumPorts];

  for (genvar gi = 0; gi < NumPorts; gi++) begin : g_in
    for (genvar go = 0; go < NumPorts; go++) begin : g_out
      logic wrHit;
      assign wrHit = inValid[gi] && (inDest[gi] == portIdx_t'(go));
      voq_fifo #(.Depth(QueueDepth), .Width(DataWidth)) q_i (
        .clk      (clk),
        .rstN     (rstN),
        .wrEn     (wrHit),
        .wrData   (inData[gi]),
        .rdEn     (strobe.popQ[gi][go]),
        .rdData   (headM[gi][go]),
        .notEmpty (notEmpty[gi][go]),
        .full     (fullM[gi][go])
      );
    end
  end

  always_comb begin
    for (int i = 0; i < int'(NumPorts); i++) begin
      inReady[i] = !fullM[i][inDest[i]];
    end
  end

  // Crossbar: one mux per egress port selecting the granted ingress head
  always_comb begin
    for (int o = 0; o < int'(NumPorts); o++) begin
      outData[o] = strobe.outFire[o] ? headM[strobe.outSel[o]][o] : '0;
    end
  end
endmodule

// File: rtl/voq_control.sv
module voq_control
  import voq_pkg::*;
(
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [NumPorts-1:0][NumPorts-1:0] notEmpty,
  output xbarStrobe_t                       strobe,
  output portIdx_t [NumPorts-1:0]           rrPtr
);
  logic [NumPorts-1:0] gntValid;
  portIdx_t [NumPorts-1:0] gntIdx;
  logic [NumPorts-1:0] fire;

  for (genvar go = 0; go < NumPorts; go++) begin : g_arb
    logic [NumPorts-1:0] reqCol;
    always_comb begin
      for (int i = 0; i < int'(NumPorts); i++) reqCol[i] = notEmpty[i][go];
    end
    voq_rr_arb arb_i (
      .req      (reqCol),
      .ptr      (rrPtr[go]),
      .gntValid (gntValid[go]),
      .gntIdx   (gntIdx[go])
    );
  end

  // Each ingress keeps only its lowest-numbered grant
  always_comb begin
    fire = '0;
    for (int i = 0; i < int'(NumPorts); i++) begin
      logic taken;
      taken = 1'b0;
      for (int o = 0; o < int'(NumPorts); o++) begin
        if (!taken && gntValid[o] && gntIdx[o] == portIdx_t'(i)) begin
          fire[o] = 1'b1;
          taken   = 1'b1;
        end
      end
    end
  end

  always_comb begin
    strobe.outFire = fire;
    strobe.outSel  = gntIdx;
    for (int i = 0; i < int'(NumPorts); i++) begin
      for (int o = 0; o < int'(NumPorts); o++) begin
        strobe.popQ[i][o] = fire[o] && (gntIdx[o] == portIdx_t'(i));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrPtr <= '0;
    end else begin
      for (int o = 0; o < int'(NumPorts); o++) begin
        if (fire[o]) begin
          rrPtr[o] <= (gntIdx[o] == portIdx_t'(NumPorts - 1)) ? '0 : gntIdx[o] + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/voq_xbar_switch.sv
module voq_xbar_switch
  import voq_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NumPorts-1:0]     inValid,
  input  portIdx_t [NumPorts-1:0] inDest,
  input  cell_t [NumPorts-1:0]    inData,
  output logic [NumPorts-1:0]     inReady,
  output logic [NumPorts-1:0]     outValid,
  output cell_t [NumPorts-1:0]    outData
);
  xbarStrobe_t                       strobe;
  logic [NumPorts-1:0][NumPorts-1:0] notEmpty;
  portIdx_t [NumPorts-1:0]           rrPtr;

  voq_control ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .notEmpty (notEmpty),
    .strobe   (strobe),
    .rrPtr    (rrPtr)
  );

  voq_datapath dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inDest   (inDest),
    .inData   (inData),
    .strobe   (strobe),
    .inReady  (inReady),
    .outData  (outData),
    .notEmpty (notEmpty)
  );

  assign outValid = strobe.outFire;
endmodule

// File: rtl/voq_xbar_switch_chk.sv
module voq_xbar_switch_chk
  import voq_pkg::*;
(
  input logic                              clk,
  input logic                              rstN,
  input xbarStrobe_t                       strobe,
  input logic [NumPorts-1:0][NumPorts-1:0] notEmpty,
  input portIdx_t [NumPorts-1:0]           rrPtr,
  input logic [NumPorts-1:0]               outValid
);
  logic [NumPorts-1:0][NumPorts-1:0] popByOut; // [egress][ingress]
  always_comb begin
    for (int i = 0; i < int'(NumPorts); i++)
      for (int o = 0; o < int'(NumPorts); o++)
        popByOut[o][i] = strobe.popQ[i][o];
  end

  for (genvar gi = 0; gi < NumPorts; gi++) begin : g_in
    p_ingress_single_r2: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(strobe.popQ[gi]));
    for (genvar go = 0; go < NumPorts; go++) begin : g_q
      p_loser_held_r3: assert property (@(posedge clk) disable iff (!rstN)
        (notEmpty[gi][go] && !strobe.popQ[gi][go]) |=> notEmpty[gi][go]);
    end
  end

  for (genvar go = 0; go < NumPorts; go++) begin : g_out
    p_egress_single_r2: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(popByOut[go]));
    p_fire_has_cell_r4: assert property (@(posedge clk) disable iff (!rstN)
      outValid[go] |-> notEmpty[strobe.outSel[go]][go]);
    p_ptr_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
      !outValid[go] |=> $stable(rrPtr[go]));
  end
endmodule

bind voq_xbar_switch voq_xbar_switch_chk chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .strobe   (strobe),
  .notEmpty (notEmpty),
  .rrPtr    (rrPtr),
  .outValid (outValid)
);

// File: tb/voq_xbar_switch_tb.sv
module voq_xbar_switch_tb_top;
  import voq_pkg::*;

  localparam int ClkPeriod = 10;
  localparam int NP = int'(NumPorts);
  localparam int QD = int'(QueueDepth);

  logic clk = 1'b0;
  logic rstN;
  logic [NumPorts-1:0]     inValid;
  portIdx_t [NumPorts-1:0] inDest;
  cell_t [NumPorts-1:0]    inData;
  logic [NumPorts-1:0]     inReady;
  logic [NumPorts-1:0]     outValid;
  cell_t [NumPorts-1:0]    outData;

  always #(ClkPeriod/2) clk = ~clk;

  voq_xbar_switch dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inDest(inDest),
    .inData(inData), .inReady(inReady), .outValid(outValid), .outData(outData)
  );

  int checks = 0;
  int errors = 0;
  int seq = 0;
  int accepted = 0;
  int delivered = 0;
  int multiGrantEvents = 0;
  int readyLowEvents = 0;
  int unsigned seedSink;

  cell_t mMem [NP][NP][QD];
  int    mCnt [NP][NP];
  int    mPtr [NP];

  logic [NP-1:0] drvValid;
  int            drvDest [NP];
  logic [NP-1:0] obsValid;
  cell_t         obsData [NP];
  cell_t         lastIn [NP];

  task automatic checkEq(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // One cycle: drive, compare against the queue model, advance the model
  task automatic step();
    int  sel [NP];
    bit  pre [NP];
    bit  fire [NP];
    bit  expRdy [NP];
    @(negedge clk);
    for (int i = 0; i < NP; i++) begin
      inValid[i] = drvValid[i];
      inDest[i]  = portIdx_t'(drvDest[i]);
      inData[i]  = {8'(i), 24'(seq)};
      lastIn[i]  = inData[i];
      seq++;
    end
    #1;
    for (int o = 0; o < NP; o++) begin
      pre[o] = 0; sel[o] = 0;
      for (int k = 0; k < NP; k++) begin
        int c;
        c = (mPtr[o] + k) % NP;
        if (!pre[o] && mCnt[c][o] > 0) begin pre[o] = 1; sel[o] = c; end
      end
    end
    for (int o = 0; o < NP; o++) fire[o] = 0;
    for (int i = 0; i < NP; i++) begin
      int hits;
      hits = 0;
      for (int o = 0; o < NP; o++) begin
        if (pre[o] && sel[o] == i) begin
          if (hits == 0) fire[o] = 1;
          hits++;
        end
      end
      if (hits > 1) multiGrantEvents++;
    end
    for (int o = 0; o < NP; o++) begin
      checkEq("R2 R5 R6 R7", $sformatf("outValid[%0d]", o), 32'(outValid[o]), 32'(fire[o]));
      if (fire[o])
        checkEq("R1", $sformatf("outData[%0d]", o), outData[o], mMem[sel[o]][o][0]);
      obsValid[o] = outValid[o];
      obsData[o]  = outData[o];
    end
    for (int i = 0; i < NP; i++) begin
      expRdy[i] = mCnt[i][drvDest[i]] < QD;
      if (!expRdy[i]) readyLowEvents++;
      checkEq("R8", $sformatf("inReady[%0d]", i), 32'(inReady[i]), 32'(expRdy[i]));
    end
    for (int o = 0; o < NP; o++) begin
      if (fire[o]) begin
        int s;
        s = sel[o];
        for (int k = 0; k < QD - 1; k++) mMem[s][o][k] = mMem[s][o][k+1];
        mCnt[s][o]--;
        mPtr[o] = (s + 1) % NP;
        delivered++;
      end
    end
    for (int i = 0; i < NP; i++) begin
      if (drvValid[i] && expRdy[i]) begin
        mMem[i][drvDest[i]][mCnt[i][drvDest[i]]] = lastIn[i];
        mCnt[i][drvDest[i]]++;
        accepted++;
      end
    end
  endtask

  task automatic setIdle();
    drvValid = '0;
    for (int i = 0; i < NP; i++) drvDest[i] = 0;
  endtask

  initial begin
    #(ClkPeriod * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit    holSeen;
    cell_t holCell;
    seedSink = $urandom(32'h5EED_0042);
    for (int i = 0; i < NP; i++) begin
      mPtr[i] = 0;
      for (int o = 0; o < NP; o++) mCnt[i][o] = 0;
    end
    rstN = 1'b0;
    inValid = '0; inDest = '0; inData = '0;
    setIdle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    checkEq("R9", "outValid in reset", 32'(outValid), 32'h0);
    checkEq("R9", "inReady in reset", 32'(inReady), {{(32-NP){1'b0}}, {NP{1'b1}}});
    rstN = 1'b1;

    // R10: single cell, ingress 2 to egress 3
    drvValid = '0; drvValid[2] = 1'b1; drvDest[2] = 3;
    step();
    checkEq("R10", "outValid same cycle as offer", 32'(obsValid[3]), 32'h0);
    holCell = lastIn[2];
    setIdle();
    step();
    checkEq("R10", "outValid one cycle later", 32'(obsValid[3]), 32'h1);
    checkEq("R10", "outData one cycle later", obsData[3], holCell);
    step();
    checkEq("R10", "cell consumed", 32'(obsValid[3]), 32'h0);

    // Hotspot: everyone to egress 0, fills queues (R8, R3, R5)
    for (int c = 0; c < 12; c++) begin
      drvValid = '1;
      for (int i = 0; i < NP; i++) drvDest[i] = 0;
      step();
    end

    // R4: ingress 0 sends one cell to idle egress 1 behind a backlog for egress 0
    drvValid = '1;
    for (int i = 0; i < NP; i++) drvDest[i] = 0;
    drvDest[0] = 1;
    step();
    holCell = lastIn[0];
    setIdle();
    holSeen = 0;
    for (int c = 0; c < 4; c++) begin
      step();
      if (obsValid[1] && obsData[1] == holCell) holSeen = 1;
    end
    checkEq("R4", "cell to free egress departed past backlog", 32'(holSeen), 32'h1);

    // Random mix with occasional hotspots
    for (int c = 0; c < 2500; c++) begin
      bit hot;
      hot = ($urandom % 8) == 0;
      for (int i = 0; i < NP; i++) begin
        drvValid[i] = ($urandom % 4) != 0;
        drvDest[i]  = hot ? 1 : int'($urandom % NP);
      end
      step();
    end

    // Drain
    setIdle();
    for (int c = 0; c < 40; c++) step();
    checkEq("R3", "delivered equals accepted", 32'(delivered), 32'(accepted));
    checkEq("R9", "inReady after drain", 32'(inReady), {{(32-NP){1'b0}}, {NP{1'b1}}});
    checkEq("R7", "multi-grant cases exercised", 32'(multiGrantEvents > 0), 32'h1);
    checkEq("R8", "full queue exercised", 32'(readyLowEvents > 0), 32'h1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule